// File: doc/BRIEF.md
# Per-Bank Flash Write Guard

This block keeps write-protection state for a flash array divided into equal banks. It holds a separate protection bitmap for each of three requesters: the host, the debugger and the local controller. Software protects a run of banks with a single range command that names any combination of the three requesters. A protection bit can be set but never cleared by a command. A warm reset clears every bitmap. A lock bit, once set, freezes the bitmaps, and only a power-on reset clears it.

Each program or erase request carries a requester code and a bank number. The block checks the request against that requester's bitmap. A request to an unprotected bank is passed on one cycle later. A request to a protected bank is dropped and raises a one-cycle violation pulse instead. A status path counts how many banks, starting at bank 0, are protected without a gap in a chosen requester's bitmap, and flags the case where every bank is protected.

Top module: `wp_bank_guard`

## Requirements
- R1: After power-on reset no bank is protected for any requester, `locked` is 0, `lead_count` is 0 and `full_prot` is 0.
- R2: A range command (`set_valid` with `set_first` F, `set_count` C, `set_ifmask`) protects banks F to F+C-1 in every requester map whose mask bit is 1. Mask bit 0 is the host, bit 1 the debugger and bit 2 the local controller. Banks past the last bank are ignored. The new bits apply to requests issued in the cycle after the command.
- R3: Range commands only set bits. Banks outside the range, and banks that are already protected, keep their state.
- R4: A request with `req_if` 0 (host), 1 (debugger) or 2 (local) to an unprotected bank gives `fwd_valid`=1, with the same `fwd_if` and `fwd_bank`, in the cycle after it is issued. To a protected bank it gives `viol`=1 and `fwd_valid`=0 instead.
- R5: A request with `req_if` 3 is always treated as a violation.
- R6: `lock_req` sets `locked` from the next cycle on. While `locked` is 1, range commands change no bit.
- R7: Warm reset `rst` clears all three bitmaps and leaves `locked` unchanged. Power-on reset `por` also clears `locked`.
- R8: `lead_count` gives the number of protected banks contiguous from bank 0 in the status requester's map (local controller by default), one cycle after that map changes. `full_prot` is 1 exactly when all banks are protected.
- R9: A request issued in the same cycle as a range command covering its bank is judged against the protection state before that command.
- R10: A range command with `set_count` 0 protects nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous warm reset, active high; clears the bitmaps |
| por | input | 1 | Synchronous power-on reset, active high; clears the bitmaps and the lock |
| set_valid | input | 1 | Range protect command strobe |
| set_first | input | BANK_W | First bank of the range |
| set_count | input | CNT_W | Number of banks in the range |
| set_ifmask | input | 3 | Requester maps to update (bit0 host, bit1 debugger, bit2 local) |
| lock_req | input | 1 | Set the lock bit |
| req_valid | input | 1 | Program or erase request strobe |
| req_if | input | 2 | Requester code of the request |
| req_bank | input | BANK_W | Target bank of the request |
| fwd_valid | output | 1 | Request passed on |
| fwd_if | output | 2 | Requester code of the passed request |
| fwd_bank | output | BANK_W | Bank of the passed request |
| viol | output | 1 | Request blocked by protection |
| locked | output | 1 | Lock bit |
| lead_count | output | CNT_W | Contiguous protected banks counted from bank 0 |
| full_prot | output | 1 | All banks protected in the status map |

## Verification
A range command and a request to a bank inside that range can arrive in the same cycle. The bench raises both strobes together, for the debugger on bank 50. It expects the request to pass, because the block reads the old map, and it expects a repeat of the same request one cycle later to be blocked. A lock and a warm reset are also applied in sequence. The bench checks that the lock survives the warm reset and keeps the cleared bitmaps from being rebuilt.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int unsigned NUM_IF = 3;
  localparam int unsigned IF_W   = 2;

  typedef enum logic [IF_W-1:0] {
    IF_HOST  = 2'd0,
    IF_DEBUG = 2'd1,
    IF_LOCAL = 2'd2,
    IF_NONE  = 2'd3
  } if_id_e;
endpackage

// File: rtl/wp_bitmap.sv
module wp_bitmap #(
  parameter int unsigned NUM_BANKS = 256,
  parameter int unsigned BANK_W    = $clog2(NUM_BANKS),
  parameter int unsigned CNT_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 por,
  input  logic                 set_en,
  input  logic                 locked,
  input  logic [BANK_W-1:0]    set_first,
  input  logic [CNT_W-1:0]     set_count,
  output logic [NUM_BANKS-1:0] bits
);
  localparam int unsigned EW = CNT_W + 1;

  logic [EW-1:0]        lo_idx;
  logic [EW-1:0]        hi_idx;
  logic [NUM_BANKS-1:0] hit;

  assign lo_idx = EW'(set_first);
  assign hi_idx = EW'(set_first) + EW'(set_count);

  // one range comparator per bank, all evaluated in the same cycle
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [EW-1:0] B_IDX = EW'(b);
    assign hit[b] = set_en && !locked && (B_IDX >= lo_idx) && (B_IDX < hi_idx);
  end

  always_ff @(posedge clk) begin
    if (rst || por) bits <= '0;
    else            bits <= bits | hit;
  end

  // R3
  set_only_chk: assert property (@(posedge clk) disable iff (rst || por)
    (!$past(rst) && !$past(por)) |-> ((bits & $past(bits)) == $past(bits)));

  // R6
  lock_freeze_chk: assert property (@(posedge clk) disable iff (rst || por)
    (!$past(rst) && !$past(por) && $past(locked)) |-> $stable(bits));
endmodule

// File: rtl/wp_req_check.sv
module wp_req_check
  import wp_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 256,
  parameter int unsigned BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              por,
  input  logic                              req_valid,
  input  if_id_e                            req_if,
  input  logic [BANK_W-1:0]                 req_bank,
  input  logic [NUM_IF-1:0][NUM_BANKS-1:0]  prot,
  output logic                              fwd_valid,
  output if_id_e                            fwd_if,
  output logic [BANK_W-1:0]                 fwd_bank,
  output logic                              viol
);
  logic blocked;

  always_comb begin
    case (req_if)
      IF_HOST:  blocked = prot[0][req_bank];
      IF_DEBUG: blocked = prot[1][req_bank];
      IF_LOCAL: blocked = prot[2][req_bank];
      default:  blocked = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || por) begin
      fwd_valid <= 1'b0;
      viol      <= 1'b0;
      fwd_if    <= IF_HOST;
      fwd_bank  <= '0;
    end else begin
      fwd_valid <= req_valid && !blocked;
      viol      <= req_valid && blocked;
      fwd_if    <= req_if;
      fwd_bank  <= req_bank;
    end
  end

  // R4
  excl_out_chk: assert property (@(posedge clk) disable iff (rst || por)
    !(fwd_valid && viol));

  // R4
  one_result_chk: assert property (@(posedge clk) disable iff (rst || por)
    (!$past(rst) && !$past(por) && $past(req_valid)) |-> (fwd_valid || viol));

  // R5
  bad_if_chk: assert property (@(posedge clk) disable iff (rst || por)
    (!$past(rst) && !$past(por) && $past(req_valid) && $past(req_if) == IF_NONE) |-> viol);
endmodule

// File: rtl/wp_lead_scan.sv
module wp_lead_scan #(
  parameter int unsigned NUM_BANKS = 256,
  parameter int unsigned CNT_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 por,
  input  logic [NUM_BANKS-1:0] bits,
  output logic [CNT_W-1:0]     lead_count,
  output logic                 full_prot
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_BANKS);

  logic [CNT_W-1:0] first_gap;

  // lowest unprotected bank index; NUM_BANKS when there is none
  always_comb begin
    first_gap = FULL;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (!bits[i]) first_gap = CNT_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || por) begin
      lead_count <= '0;
      full_prot  <= 1'b0;
    end else begin
      lead_count <= first_gap;
      full_prot  <= (first_gap == FULL);
    end
  end

  // R8
  full_tracks_map_chk: assert property (@(posedge clk) disable iff (rst || por)
    (!$past(rst) && !$past(por)) |-> (full_prot == (&$past(bits))));
endmodule

// File: rtl/wp_bank_guard.sv
module wp_bank_guard
  import wp_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 256,
  parameter int unsigned STATUS_IF = 2,
  parameter int unsigned BANK_W    = $clog2(NUM_BANKS),
  parameter int unsigned CNT_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              set_valid,
  input  logic [BANK_W-1:0] set_first,
  input  logic [CNT_W-1:0]  set_count,
  input  logic [2:0]        set_ifmask,
  input  logic              lock_req,
  input  logic              req_valid,
  input  logic [1:0]        req_if,
  input  logic [BANK_W-1:0] req_bank,
  output logic              fwd_valid,
  output logic [1:0]        fwd_if,
  output logic [BANK_W-1:0] fwd_bank,
  output logic              viol,
  output logic              locked,
  output logic [CNT_W-1:0]  lead_count,
  output logic              full_prot
);
  logic [NUM_IF-1:0][NUM_BANKS-1:0] prot;
  logic                             lock_q;
  if_id_e                           fwd_if_e;

  // lock survives warm reset; only power-on reset frees it
  always_ff @(posedge clk) begin
    if (por)           lock_q <= 1'b0;
    else if (lock_req) lock_q <= 1'b1;
  end
  assign locked = lock_q;

  for (genvar g = 0; g < NUM_IF; g++) begin : g_map
    wp_bitmap #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .CNT_W     (CNT_W)
    ) i_map (
      .clk       (clk),
      .rst       (rst),
      .por       (por),
      .set_en    (set_valid && set_ifmask[g]),
      .locked    (lock_q),
      .set_first (set_first),
      .set_count (set_count),
      .bits      (prot[g])
    );
  end

  wp_req_check #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) i_check (
    .clk       (clk),
    .rst       (rst),
    .por       (por),
    .req_valid (req_valid),
    .req_if    (if_id_e'(req_if)),
    .req_bank  (req_bank),
    .prot      (prot),
    .fwd_valid (fwd_valid),
    .fwd_if    (fwd_if_e),
    .fwd_bank  (fwd_bank),
    .viol      (viol)
  );
  assign fwd_if = fwd_if_e;

  wp_lead_scan #(
    .NUM_BANKS (NUM_BANKS),
    .CNT_W     (CNT_W)
  ) i_scan (
    .clk        (clk),
    .rst        (rst),
    .por        (por),
    .bits       (prot[STATUS_IF]),
    .lead_count (lead_count),
    .full_prot  (full_prot)
  );

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (por)
    (!$past(por) && $past(lock_q)) |-> lock_q);

  // R6
  lock_rise_chk: assert property (@(posedge clk) disable iff (por)
    (!$past(por) && $past(lock_req)) |-> lock_q);
endmodule

// File: tb/test_wp_bank_guard.sv
module test_wp_bank_guard;
  localparam int NB = 256;
  localparam int BW = 8;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          por = 1'b1;
  logic          set_valid = 1'b0;
  logic [BW-1:0] set_first = '0;
  logic [CW-1:0] set_count = '0;
  logic [2:0]    set_ifmask = '0;
  logic          lock_req = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_if = '0;
  logic [BW-1:0] req_bank = '0;
  logic          fwd_valid;
  logic [1:0]    fwd_if;
  logic [BW-1:0] fwd_bank;
  logic          viol;
  logic          locked;
  logic [CW-1:0] lead_count;
  logic          full_prot;

  int checks = 0;
  int fails  = 0;
  bit exp_prot [3][NB];
  bit exp_lock = 1'b0;

  always #5 clk = ~clk;

  wp_bank_guard i_wp_bank_guard (
    .clk(clk), .rst(rst), .por(por),
    .set_valid(set_valid), .set_first(set_first), .set_count(set_count),
    .set_ifmask(set_ifmask), .lock_req(lock_req),
    .req_valid(req_valid), .req_if(req_if), .req_bank(req_bank),
    .fwd_valid(fwd_valid), .fwd_if(fwd_if), .fwd_bank(fwd_bank), .viol(viol),
    .locked(locked), .lead_count(lead_count), .full_prot(full_prot)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_set(input int first, input int count, input logic [2:0] mask);
    if (!exp_lock)
      for (int m = 0; m < 3; m++)
        if (mask[m])
          for (int b = first; b < first + count; b++)
            if (b < NB) exp_prot[m][b] = 1'b1;
  endtask

  task automatic model_clear();
    for (int m = 0; m < 3; m++)
      for (int b = 0; b < NB; b++) exp_prot[m][b] = 1'b0;
  endtask

  task automatic do_set(input int first, input int count, input logic [2:0] mask);
    set_valid = 1'b1; set_first = BW'(first); set_count = CW'(count); set_ifmask = mask;
    @(negedge clk);
    set_valid = 1'b0;
    model_set(first, count, mask);
  endtask

  task automatic do_req(input int ifid, input int bank, input string req);
    bit blk;
    req_valid = 1'b1; req_if = 2'(ifid); req_bank = BW'(bank);
    @(negedge clk);
    req_valid = 1'b0;
    blk = (ifid == 3) ? 1'b1 : exp_prot[ifid][bank];
    chk(viol == blk, req, int'(viol), int'(blk));
    chk(fwd_valid == !blk, req, int'(fwd_valid), int'(!blk));
    if (!blk) begin
      chk(fwd_bank == BW'(bank), req, int'(fwd_bank), bank);
      chk(fwd_if == 2'(ifid), req, int'(fwd_if), ifid);
    end
  endtask

  task automatic chk_lead(input string req);
    int e;
    @(negedge clk);
    e = NB;
    for (int b = NB - 1; b >= 0; b--) if (!exp_prot[2][b]) e = b;
    chk(lead_count == CW'(e), req, int'(lead_count), e);
    chk(full_prot == (e == NB), req, int'(full_prot), int'(e == NB));
  endtask

  task automatic t_reset();
    chk(locked == 1'b0, "R1", int'(locked), 0);
    chk(lead_count == '0, "R1", int'(lead_count), 0);
    chk(full_prot == 1'b0, "R1", int'(full_prot), 0);
    do_req(0, 5, "R1");
    do_req(2, 255, "R1");
  endtask

  task automatic t_range();
    do_set(10, 4, 3'b001);
    do_req(0, 10, "R2");
    do_req(0, 13, "R2");
    do_req(0, 14, "R2");
    do_req(0, 9, "R2");
    do_req(1, 10, "R4");
    do_req(2, 11, "R4");
    do_set(250, 20, 3'b100);
    do_req(2, 255, "R2");
    do_req(2, 249, "R2");
  endtask

  task automatic t_set_only();
    do_set(12, 1, 3'b001);
    do_req(0, 10, "R3");
    do_req(0, 12, "R3");
    do_set(100, 0, 3'b111);
    do_req(0, 100, "R10");
    do_req(2, 100, "R10");
  endtask

  task automatic t_bad_if();
    do_req(3, 200, "R5");
  endtask

  task automatic t_lead();
    chk_lead("R8");
    do_set(0, 100, 3'b100);
    chk_lead("R8");
    do_set(100, 150, 3'b100);
    chk_lead("R8");
  endtask

  task automatic t_same_cycle();
    set_valid = 1'b1; set_first = BW'(50); set_count = CW'(1); set_ifmask = 3'b010;
    req_valid = 1'b1; req_if = 2'd1; req_bank = BW'(50);
    @(negedge clk);
    set_valid = 1'b0; req_valid = 1'b0;
    chk(fwd_valid == 1'b1, "R9", int'(fwd_valid), 1);
    chk(viol == 1'b0, "R9", int'(viol), 0);
    model_set(50, 1, 3'b010);
    do_req(1, 50, "R9");
  endtask

  task automatic t_lock();
    lock_req = 1'b1;
    @(negedge clk);
    lock_req = 1'b0;
    exp_lock = 1'b1;
    chk(locked == 1'b1, "R6", int'(locked), 1);
    do_set(60, 1, 3'b010);
    do_req(1, 60, "R6");
  endtask

  task automatic t_resets();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    chk(locked == 1'b1, "R7", int'(locked), 1);
    do_req(0, 10, "R7");
    do_req(2, 0, "R7");
    chk_lead("R7");
    do_set(0, 4, 3'b001);
    do_req(0, 2, "R7");
    por = 1'b1;
    @(negedge clk);
    por = 1'b0;
    exp_lock = 1'b0;
    chk(locked == 1'b0, "R7", int'(locked), 0);
    do_set(0, 4, 3'b001);
    do_req(0, 2, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0; por = 1'b0;
    @(negedge clk);
    t_reset();
    t_range();
    t_set_only();
    t_bad_if();
    t_lead();
    t_same_cycle();
    t_lock();
    t_resets();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule